// File: doc/BRIEF.md
# Quad-channel FIFO ready aggregator

This block watches the FIFO fill state of four serial channels and merges it into two shared active-low request lines, one for receive and one for transmit. A CPU or DMA engine uses them to learn that at least one channel needs service. It also exposes the per-channel ready bits, so the servicing agent can see which channel raised the request.

Each channel supplies the following as plain inputs:
- a receive FIFO fill count;
- a receive timeout flag;
- the number of free transmit FIFO entries;
- a receive trigger level and a transmit trigger level;
- an enable that takes the channel out of the merge.

All counts are 7 bits wide and range from 0 to 64. The FIFOs, the timeout timer and the register file sit outside this block. Both the shared lines and the per-channel vectors come from registers, so they follow the inputs with one clock of latency.

Top module: `qfifo_ready_agg`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it, `rx_rdy_n` and `tx_rdy_n` are 1 and `rx_ready_vec` and `tx_ready_vec` are all zero.
- R2: Bit i of `rx_ready_vec` is 1 when channel i is enabled, its receive count is nonzero and the count is at least its receive trigger. A trigger of 0 acts as 1. Channel i's count and trigger sit in bits [i*7 +: 7] of their buses.
- R3: An enabled channel with a nonzero receive count and its timeout flag set is receive-ready whatever its trigger level.
- R4: A channel with a receive count of zero is never receive-ready, even with the timeout flag set. When every receive count is zero, `rx_rdy_n` is 1.
- R5: Bit i of `tx_ready_vec` is 1 when channel i is enabled, its free-space count is nonzero and the count is at least its transmit trigger. A trigger of 0 acts as 1.
- R6: When every transmit free-space count is zero (all FIFOs full), `tx_rdy_n` is 1.
- R7: A channel whose `ch_en` bit is 0 sets neither vector bit, and it cannot pull either shared line low.
- R8: `rx_rdy_n` is 0 exactly when any bit of `rx_ready_vec` is 1. `tx_rdy_n` is 0 exactly when any bit of `tx_ready_vec` is 1.
- R9: All four outputs reflect the inputs sampled at the preceding rising clock edge, one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_en | input | 4 | Per-channel FIFO enable |
| rx_count | input | 28 | Receive fill counts, 7 bits per channel |
| rx_timeout | input | 4 | Per-channel receive timeout flag |
| rx_trig | input | 28 | Receive trigger levels, 7 bits per channel |
| tx_space | input | 28 | Transmit free-entry counts, 7 bits per channel |
| tx_trig | input | 28 | Transmit trigger levels, 7 bits per channel |
| rx_ready_vec | output | 4 | Registered per-channel receive-ready bits |
| tx_ready_vec | output | 4 | Registered per-channel transmit-ready bits |
| rx_rdy_n | output | 1 | Shared active-low receive request |
| tx_rdy_n | output | 1 | Shared active-low transmit request |

## Verification
The bench probes each threshold from both sides, at one below, exactly at and one above the trigger. A design with an off-by-one comparison would flip the vector bit on the wrong count. A zero trigger level tests whether a design treats it as "always ready" and raises a request on an empty or full FIFO. A timeout on an empty FIFO tests whether a design lets the timeout pull the receive line low with no data present. A disabled channel that holds fully ready inputs shows whether a design leaks masked channels into the merge. A stream of random patterns compared on every clock catches a missing or extra register stage.

// File: rtl/qfa_pkg.sv
package qfa_pkg;
  // Ready conditions of one channel, before registration
  typedef struct packed {
    logic rx;
    logic tx;
  } ch_rdy_t;
endpackage

// File: rtl/qfa_chan.sv
module qfa_chan #(
  parameter int CNT_W = 7
) (
  input  logic             en,
  input  logic [CNT_W-1:0] rx_cnt,
  input  logic             rx_to,
  input  logic [CNT_W-1:0] rx_lvl,
  input  logic [CNT_W-1:0] tx_free,
  input  logic [CNT_W-1:0] tx_lvl,
  output qfa_pkg::ch_rdy_t rdy
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] rx_thr, tx_thr;
  logic             rx_nonempty, tx_nonfull, rx_hit, tx_hit;

  always_comb begin
    // A zero level is promoted to one, so an empty/full FIFO never requests
    rx_thr      = (rx_lvl == '0) ? ONE : rx_lvl;
    tx_thr      = (tx_lvl == '0) ? ONE : tx_lvl;
    rx_nonempty = (rx_cnt != '0);
    tx_nonfull  = (tx_free != '0);
    rx_hit      = (rx_cnt >= rx_thr) || rx_to;
    tx_hit      = (tx_free >= tx_thr);
    rdy.rx      = en && rx_nonempty && rx_hit;
    rdy.tx      = en && tx_nonfull && tx_hit;
  end
endmodule

// File: rtl/qfa_merge.sv
module qfa_merge #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] rx_v,
  input  logic [NUM_CH-1:0] tx_v,
  output logic [NUM_CH-1:0] rx_vec_q,
  output logic [NUM_CH-1:0] tx_vec_q,
  output logic              rx_n_q,
  output logic              tx_n_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_vec_q <= '0;
      tx_vec_q <= '0;
      rx_n_q   <= 1'b1;
      tx_n_q   <= 1'b1;
    end else begin
      rx_vec_q <= rx_v;
      tx_vec_q <= tx_v;
      rx_n_q   <= ~(|rx_v);
      tx_n_q   <= ~(|tx_v);
    end
  end

  AST_RX_ANY_LOW: assert property (@(posedge clk) disable iff (rst)
    (|rx_v) |=> (!rx_n_q && rx_vec_q != '0)); // R8
  AST_TX_ANY_LOW: assert property (@(posedge clk) disable iff (rst)
    (|tx_v) |=> (!tx_n_q && tx_vec_q != '0)); // R8
  AST_RX_NONE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (rx_v == '0) |=> (rx_n_q && rx_vec_q == '0)); // R9
  AST_TX_NONE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (tx_v == '0) |=> (tx_n_q && tx_vec_q == '0)); // R9
endmodule

// File: rtl/qfifo_ready_agg.sv
module qfifo_ready_agg #(
  parameter int NUM_CH     = 4,
  parameter int FIFO_DEPTH = 64,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_CH-1:0]       ch_en,
  input  logic [NUM_CH*CNT_W-1:0] rx_count,
  input  logic [NUM_CH-1:0]       rx_timeout,
  input  logic [NUM_CH*CNT_W-1:0] rx_trig,
  input  logic [NUM_CH*CNT_W-1:0] tx_space,
  input  logic [NUM_CH*CNT_W-1:0] tx_trig,
  output logic [NUM_CH-1:0]       rx_ready_vec,
  output logic [NUM_CH-1:0]       tx_ready_vec,
  output logic                    rx_rdy_n,
  output logic                    tx_rdy_n
);
  qfa_pkg::ch_rdy_t flags [NUM_CH];
  logic [NUM_CH-1:0] rx_v, tx_v;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    qfa_chan #(.CNT_W(CNT_W)) chan_i (
      .en      (ch_en[i]),
      .rx_cnt  (rx_count[i*CNT_W +: CNT_W]),
      .rx_to   (rx_timeout[i]),
      .rx_lvl  (rx_trig[i*CNT_W +: CNT_W]),
      .tx_free (tx_space[i*CNT_W +: CNT_W]),
      .tx_lvl  (tx_trig[i*CNT_W +: CNT_W]),
      .rdy     (flags[i])
    );
    assign rx_v[i] = flags[i].rx;
    assign tx_v[i] = flags[i].tx;

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
      !ch_en[i] |=> (!rx_ready_vec[i] && !tx_ready_vec[i])); // R7
    AST_TIMEOUT_WAKES: assert property (@(posedge clk) disable iff (rst)
      (ch_en[i] && rx_timeout[i] && rx_count[i*CNT_W +: CNT_W] != '0)
      |=> rx_ready_vec[i]); // R3
  end

  qfa_merge #(.NUM_CH(NUM_CH)) merge_i (
    .clk      (clk),
    .rst      (rst),
    .rx_v     (rx_v),
    .tx_v     (tx_v),
    .rx_vec_q (rx_ready_vec),
    .tx_vec_q (tx_ready_vec),
    .rx_n_q   (rx_rdy_n),
    .tx_n_q   (tx_rdy_n)
  );

  logic all_rx_empty, all_tx_full;
  always_comb begin
    all_rx_empty = 1'b1;
    all_tx_full  = 1'b1;
    for (int k = 0; k < NUM_CH; k++) begin
      if (rx_count[k*CNT_W +: CNT_W] != '0) all_rx_empty = 1'b0;
      if (tx_space[k*CNT_W +: CNT_W] != '0) all_tx_full  = 1'b0;
    end
  end

  AST_EMPTY_RX_IDLE: assert property (@(posedge clk) disable iff (rst)
    all_rx_empty |=> rx_rdy_n); // R4
  AST_FULL_TX_IDLE: assert property (@(posedge clk) disable iff (rst)
    all_tx_full |=> tx_rdy_n); // R6
endmodule

// File: tb/qfifo_ready_agg_tb_top.sv
module qfifo_ready_agg_tb_top;
  localparam int NC = 4;
  localparam int CW = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NC-1:0]    ch_en = '0, rx_timeout = '0;
  logic [NC*CW-1:0] rx_count = '0, rx_trig = '0, tx_space = '0, tx_trig = '0;
  logic [NC-1:0]    rx_ready_vec, tx_ready_vec;
  logic             rx_rdy_n, tx_rdy_n;

  always #4 clk = ~clk; // 125 MHz

  qfifo_ready_agg dut_i (
    .clk(clk), .rst(rst), .ch_en(ch_en), .rx_count(rx_count),
    .rx_timeout(rx_timeout), .rx_trig(rx_trig), .tx_space(tx_space),
    .tx_trig(tx_trig), .rx_ready_vec(rx_ready_vec), .tx_ready_vec(tx_ready_vec),
    .rx_rdy_n(rx_rdy_n), .tx_rdy_n(tx_rdy_n)
  );

  int total = 0, bad = 0;
  int m_rxc[NC], m_rxt[NC], m_txs[NC], m_txt[NC];
  bit m_to[NC], m_en[NC];
  bit m_rst;
  logic [NC-1:0] exp_rxv = '0, exp_txv = '0;
  logic exp_rxn = 1'b1, exp_txn = 1'b1;
  string prev_tag = "R1";

  task automatic chk(string tag, string what, logic [NC-1:0] act, logic [NC-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Compare outputs against the expectation of the previous drive, then drive anew
  task automatic apply(string tag);
    @(negedge clk);
    chk(prev_tag, "rx_ready_vec", rx_ready_vec, exp_rxv);
    chk(prev_tag, "tx_ready_vec", tx_ready_vec, exp_txv);
    chk(prev_tag, "rx_rdy_n", {3'b0, rx_rdy_n}, {3'b0, exp_rxn});
    chk(prev_tag, "tx_rdy_n", {3'b0, tx_rdy_n}, {3'b0, exp_txn});
    rst = m_rst;
    for (int i = 0; i < NC; i++) begin
      ch_en[i]             = m_en[i];
      rx_timeout[i]        = m_to[i];
      rx_count[i*CW +: CW] = CW'(m_rxc[i]);
      rx_trig[i*CW +: CW]  = CW'(m_rxt[i]);
      tx_space[i*CW +: CW] = CW'(m_txs[i]);
      tx_trig[i*CW +: CW]  = CW'(m_txt[i]);
    end
    for (int i = 0; i < NC; i++) begin
      int rthr = (m_rxt[i] == 0) ? 1 : m_rxt[i];
      int tthr = (m_txt[i] == 0) ? 1 : m_txt[i];
      exp_rxv[i] = !m_rst && m_en[i] && m_rxc[i] > 0 && (m_rxc[i] >= rthr || m_to[i]);
      exp_txv[i] = !m_rst && m_en[i] && m_txs[i] > 0 && m_txs[i] >= tthr;
    end
    exp_rxn = (exp_rxv == '0);
    exp_txn = (exp_txv == '0);
    prev_tag = tag;
  endtask

  task automatic set_all(int rc, int rt, bit to, int ts, int tt, bit en);
    for (int i = 0; i < NC; i++) begin
      m_rxc[i] = rc; m_rxt[i] = rt; m_to[i] = to;
      m_txs[i] = ts; m_txt[i] = tt; m_en[i] = en;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_rst = 1'b1;
    set_all(10, 1, 1'b1, 64, 1, 1'b1);
    @(posedge clk);
    // R1: ready conditions held during reset must not show
    repeat (3) apply("R1");
    m_rst = 1'b0;
    // R4: timeout on empty FIFOs, R6: all transmit FIFOs full
    set_all(0, 4, 1'b1, 0, 4, 1'b1);
    apply("R4");
    apply("R6");
    // R2: below, at, above trigger, plus empty
    set_all(0, 8, 1'b0, 0, 1, 1'b1);
    m_rxc[0] = 7; m_rxc[1] = 8; m_rxc[2] = 9; m_rxc[3] = 0;
    apply("R2");
    set_all(0, 0, 1'b0, 0, 1, 1'b1);
    m_rxc[1] = 1; m_rxc[3] = 64;
    apply("R2");
    set_all(63, 64, 1'b0, 0, 1, 1'b1);
    m_rxc[2] = 64;
    apply("R2");
    // R3: timeout below trigger on one channel
    set_all(1, 32, 1'b0, 0, 1, 1'b1);
    m_to[2] = 1'b1;
    apply("R3");
    // R5: transmit thresholds
    set_all(0, 1, 1'b0, 64, 16, 1'b1);
    m_txs[0] = 15; m_txs[1] = 16; m_txs[3] = 0;
    apply("R5");
    set_all(0, 1, 1'b0, 0, 0, 1'b1);
    m_txs[2] = 1;
    apply("R5");
    // R7: masked channels with fully ready inputs
    set_all(64, 1, 1'b1, 64, 1, 1'b1);
    m_en[1] = 1'b0; m_en[3] = 1'b0;
    apply("R7");
    set_all(64, 1, 1'b1, 64, 1, 1'b0);
    apply("R7");
    // R9: alternate each cycle to expose latency errors
    for (int n = 0; n < 12; n++) begin
      set_all((n % 2) ? 5 : 0, 1, 1'b0, (n % 2) ? 0 : 9, 1, 1'b1);
      apply("R9");
    end
    // R8: random patterns
    for (int n = 0; n < 300; n++) begin
      for (int i = 0; i < NC; i++) begin
        m_rxc[i] = ($urandom_range(0, 3) == 0) ? 0 : int'($urandom_range(0, 64));
        m_rxt[i] = int'($urandom_range(0, 64));
        m_to[i]  = ($urandom_range(0, 4) == 0);
        m_txs[i] = ($urandom_range(0, 3) == 0) ? 0 : int'($urandom_range(0, 64));
        m_txt[i] = int'($urandom_range(0, 64));
        m_en[i]  = ($urandom_range(0, 5) != 0);
      end
      apply("R8");
    end
    apply("R8");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule